// File: doc/BRIEF.md
# Memory-Mapped Interrupt Trigger Registers

This block is a small bank of 32-bit registers on a plain word-wide request bus: a valid strobe, a write flag, a byte address and write data. It holds two output-data words, a control word, an interrupt status word and a software interrupt word. The software interrupt word has one address that sets bits and another that clears them. The block drives a single level-sensitive interrupt line toward the host processor.

The line is not computed from pending bits and a mask. It is moved by the writes themselves. Some addresses raise it, some lower it, and some do either depending on particular data bits. Every other access leaves the line where it was. A two-state machine holds the line: `LINE_IDLE` drives it low and `LINE_ASSERTED` drives it high. A raise command moves `LINE_IDLE` to `LINE_ASSERTED`, and a lower command moves `LINE_ASSERTED` back to `LINE_IDLE`. With no command, or a command that matches the current state, the machine stays where it is.

Every accepted access gets a registered response one cycle later. That response is read data for reads, zero for writes, and an error flag for any address that maps to nothing.

Top module: `mmirq_top`

## Requirements
- R1: After reset the output-data, control, status and software words are all zero and the interrupt line is low. A control read then returns 0x0002_0000.
- R2: Writes to output data A (0x028), output data B (0x02C), control (0x04C) and status (0x050) store all 32 bits, and reads return them. A control read always shows bit 17 as 1, whatever was stored there.
- R3: A write to output data B with data bit 29 set raises the line at the clock edge that accepts the write. With bit 29 clear, that write leaves the line unchanged.
- R4: A write to control with data bit 16 set lowers the line. Without bit 16, the line keeps its level.
- R5: A write to status lowers the line if data bit 16 or bit 29 is set. Otherwise the line keeps its level.
- R6: A write to the set address (0x1F0) ORs the data into the software word and always raises the line, even when the data is zero.
- R7: A write to the clear address (0x1F4) clears the software-word bits that are 1 in the data and always lowers the line.
- R8: A read of either the set or the clear address returns the current software word.
- R9: An access to any other offset, including an offset that is not a multiple of four, changes no register and leaves the line unchanged. Such an access returns read data 0 and a one-cycle error pulse.
- R10: For each accepted access, the response valid flag and its data appear in the following cycle only. Reads, and cycles with no access, never move the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request, accepted on the same edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response for the access of the previous cycle |
| rsp_rdata | output | DATA_W | Read data; zero for writes and unmapped offsets |
| rsp_err | output | 1 | Previous access hit an unmapped offset |
| irq | output | 1 | Level interrupt line |

## Verification
Every result is due exactly one clock edge after the edge that accepts the request. Stored values, the response valid flag, the read data, the error pulse and the interrupt level all come from registers loaded on that edge. The bench drives each request on a falling edge and removes it on the next falling edge, then samples the response and the line at that same point, half a cycle after the one edge that matters. The error pulse gets a second sample one cycle later to confirm it has dropped. Hold cases are checked after both a raise and a lower, so a line that merely follows the last write cannot pass them.

// File: rtl/mmirq_pkg.sv
package mmirq_pkg;

    localparam int OFF_W = 12;

    localparam logic [OFF_W-1:0] OFF_OUTA  = 12'h028;
    localparam logic [OFF_W-1:0] OFF_OUTB  = 12'h02C;
    localparam logic [OFF_W-1:0] OFF_CTRL  = 12'h04C;
    localparam logic [OFF_W-1:0] OFF_STAT  = 12'h050;
    localparam logic [OFF_W-1:0] OFF_SWSET = 12'h1F0;
    localparam logic [OFF_W-1:0] OFF_SWCLR = 12'h1F4;

    localparam int BIT_OUTB_RAISE = 29;
    localparam int BIT_CTRL_LOWER = 16;
    localparam int BIT_STAT_LOW_A = 16;
    localparam int BIT_STAT_LOW_B = 29;
    localparam int BIT_CTRL_FORCE = 17;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_OUTA,
        SEL_OUTB,
        SEL_CTRL,
        SEL_STAT,
        SEL_SWSET,
        SEL_SWCLR
    } reg_sel_e;

    typedef enum logic [1:0] {
        CMD_HOLD,
        CMD_RAISE,
        CMD_LOWER
    } line_cmd_e;

    localparam int NPLAIN = 4;

    function automatic reg_sel_e plain_sel(input int idx);
        case (idx)
            0:       return SEL_OUTA;
            1:       return SEL_OUTB;
            2:       return SEL_CTRL;
            default: return SEL_STAT;
        endcase
    endfunction

endpackage

// File: rtl/mmirq_decode.sv
module mmirq_decode
    import mmirq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    always_comb begin
        sel = SEL_NONE;
        if (addr == ADDR_W'(OFF_OUTA))       sel = SEL_OUTA;
        else if (addr == ADDR_W'(OFF_OUTB))  sel = SEL_OUTB;
        else if (addr == ADDR_W'(OFF_CTRL))  sel = SEL_CTRL;
        else if (addr == ADDR_W'(OFF_STAT))  sel = SEL_STAT;
        else if (addr == ADDR_W'(OFF_SWSET)) sel = SEL_SWSET;
        else if (addr == ADDR_W'(OFF_SWCLR)) sel = SEL_SWCLR;
    end

endmodule

// File: rtl/mmirq_regfile.sv
module mmirq_regfile
    import mmirq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output line_cmd_e         cmd
);

    localparam logic [DATA_W-1:0] FORCE_MASK = DATA_W'(1) << BIT_CTRL_FORCE;

    logic [NPLAIN-1:0][DATA_W-1:0] plain_rd;
    logic [DATA_W-1:0]             sw_q;

    // Plain storage words: identical load-on-select registers
    for (genvar gi = 0; gi < NPLAIN; gi++) begin : g_plain
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word_q <= '0;
            else if (wr_en && sel == plain_sel(gi))
                word_q <= wdata;
        end
        assign plain_rd[gi] = word_q;
    end

    // Software word with separate set and clear aliases
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sw_q <= '0;
        else if (wr_en && sel == SEL_SWSET)
            sw_q <= sw_q | wdata;
        else if (wr_en && sel == SEL_SWCLR)
            sw_q <= sw_q & ~wdata;
    end

    always_comb begin
        unique case (sel)
            SEL_OUTA:  rdata = plain_rd[0];
            SEL_OUTB:  rdata = plain_rd[1];
            SEL_CTRL:  rdata = plain_rd[2] | FORCE_MASK;
            SEL_STAT:  rdata = plain_rd[3];
            SEL_SWSET,
            SEL_SWCLR: rdata = sw_q;
            default:   rdata = '0;
        endcase
    end

    always_comb begin
        cmd = CMD_HOLD;
        if (wr_en) begin
            unique case (sel)
                SEL_OUTB:  if (wdata[BIT_OUTB_RAISE]) cmd = CMD_RAISE;
                SEL_CTRL:  if (wdata[BIT_CTRL_LOWER]) cmd = CMD_LOWER;
                SEL_STAT:  if (wdata[BIT_STAT_LOW_A] || wdata[BIT_STAT_LOW_B]) cmd = CMD_LOWER;
                SEL_SWSET: cmd = CMD_RAISE;
                SEL_SWCLR: cmd = CMD_LOWER;
                default:   cmd = CMD_HOLD;
            endcase
        end
    end

endmodule

// File: rtl/mmirq_line_fsm.sv
module mmirq_line_fsm
    import mmirq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  line_cmd_e cmd,
    output logic      line
);

    typedef enum logic {
        LINE_IDLE,
        LINE_ASSERTED
    } line_state_e;

    line_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LINE_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_IDLE:     if (cmd == CMD_RAISE) state_d = LINE_ASSERTED;
            LINE_ASSERTED: if (cmd == CMD_LOWER) state_d = LINE_IDLE;
            default:       state_d = LINE_IDLE;
        endcase
    end

    always_comb begin
        line = (state_q == LINE_ASSERTED);
    end

endmodule

// File: rtl/mmirq_top.sv
module mmirq_top
    import mmirq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              irq
);

    reg_sel_e          sel;
    line_cmd_e         cmd;
    logic [DATA_W-1:0] rd_comb;
    logic              wr_en;
    logic              miss;

    mmirq_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (req_addr),
        .sel  (sel)
    );

    assign miss  = (sel == SEL_NONE);
    assign wr_en = req_valid && req_write && !miss;

    mmirq_regfile #(.DATA_W(DATA_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .sel   (sel),
        .wdata (req_wdata),
        .rdata (rd_comb),
        .cmd   (cmd)
    );

    mmirq_line_fsm u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (cmd),
        .line  (irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && miss;
            rsp_rdata <= (req_valid && !req_write) ? rd_comb : '0;
        end
    end

endmodule

// File: rtl/mmirq_checker.sv
module mmirq_checker
    import mmirq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              rsp_err,
    input logic              irq
);

    logic wr, rd, known;
    assign wr = req_valid && req_write;
    assign rd = req_valid && !req_write;
    assign known = (req_addr == ADDR_W'(OFF_OUTA))  || (req_addr == ADDR_W'(OFF_OUTB)) ||
                   (req_addr == ADDR_W'(OFF_CTRL))  || (req_addr == ADDR_W'(OFF_STAT)) ||
                   (req_addr == ADDR_W'(OFF_SWSET)) || (req_addr == ADDR_W'(OFF_SWCLR));

    assert_ctrl_force_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && req_addr == ADDR_W'(OFF_CTRL)) |=> rsp_rdata[BIT_CTRL_FORCE]);

    assert_outb_raise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && req_addr == ADDR_W'(OFF_OUTB) && req_wdata[BIT_OUTB_RAISE]) |=> irq);

    assert_ctrl_lower_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && req_addr == ADDR_W'(OFF_CTRL) && req_wdata[BIT_CTRL_LOWER]) |=> !irq);

    assert_stat_lower_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && req_addr == ADDR_W'(OFF_STAT) &&
         (req_wdata[BIT_STAT_LOW_A] || req_wdata[BIT_STAT_LOW_B])) |=> !irq);

    assert_set_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && req_addr == ADDR_W'(OFF_SWSET)) |=> irq);

    assert_clr_lower_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && req_addr == ADDR_W'(OFF_SWCLR)) |=> !irq);

    assert_unmapped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !known) |=> (rsp_err && rsp_rdata == '0 && $stable(irq)));

    assert_no_spurious_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || known) |=> !rsp_err);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || !req_write) |=> ($stable(irq) && rsp_valid == $past(req_valid)));

endmodule

bind mmirq_top mmirq_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err),
    .irq       (irq)
);

// File: tb/mmirq_top_tb.sv
module mmirq_top_tb;

    localparam int AW = 12;
    localparam int DW = 32;

    localparam logic [AW-1:0] A_OUTA = 12'h028;
    localparam logic [AW-1:0] A_OUTB = 12'h02C;
    localparam logic [AW-1:0] A_CTRL = 12'h04C;
    localparam logic [AW-1:0] A_STAT = 12'h050;
    localparam logic [AW-1:0] A_SET  = 12'h1F0;
    localparam logic [AW-1:0] A_CLR  = 12'h1F4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          rsp_err;
    logic          irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    mmirq_top #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err),
        .irq       (irq)
    );

    task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    // One access: driven at a falling edge, accepted at the next rising edge,
    // response and line sampled at the following falling edge.
    task automatic access(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          output logic [DW-1:0] rdat, output logic err);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        check("R10 rsp_valid", {31'b0, rsp_valid}, 32'd1);
        rdat = rsp_rdata;
        err  = rsp_err;
    endtask

    task automatic wr_irq(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic exp_irq);
        logic [DW-1:0] r; logic e;
        access(1'b1, a, d, r, e);
        check({tag, " irq"}, {31'b0, irq}, {31'b0, exp_irq});
        check({tag, " err"}, {31'b0, e}, 32'd0);
    endtask

    task automatic rd_chk(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] exp);
        logic [DW-1:0] r; logic e;
        access(1'b0, a, '0, r, e);
        check(tag, r, exp);
    endtask

    task automatic t_reset;
        check("R1 irq after reset", {31'b0, irq}, 32'd0);
        check("R1 rsp_valid idle", {31'b0, rsp_valid}, 32'd0);
        rd_chk("R1 outa", A_OUTA, 32'h0);
        rd_chk("R1 outb", A_OUTB, 32'h0);
        rd_chk("R1 ctrl", A_CTRL, 32'h0002_0000);
        rd_chk("R1 stat", A_STAT, 32'h0);
        rd_chk("R1 sw",   A_SET,  32'h0);
    endtask

    task automatic t_store;
        wr_irq("R2 outa", A_OUTA, 32'hA5A5_1234, 1'b0);
        wr_irq("R3 outb no bit29", A_OUTB, 32'hDFFF_FFFF, 1'b0);
        wr_irq("R2 ctrl", A_CTRL, 32'h1234_0001, 1'b0);
        wr_irq("R5 stat no lower", A_STAT, 32'h0000_00F0, 1'b0);
        rd_chk("R2 outa rb", A_OUTA, 32'hA5A5_1234);
        rd_chk("R2 outb rb", A_OUTB, 32'hDFFF_FFFF);
        rd_chk("R2 ctrl rb forced", A_CTRL, 32'h1236_0001);
        rd_chk("R2 stat rb", A_STAT, 32'h0000_00F0);
    endtask

    task automatic t_line_rules;
        wr_irq("R3 outb raise", A_OUTB, 32'h2000_0000, 1'b1);
        wr_irq("R3 outb hold high", A_OUTB, 32'h0000_0001, 1'b1);
        wr_irq("R4 ctrl hold", A_CTRL, 32'hFFFE_FFFF, 1'b1);
        rd_chk("R10 read keeps line", A_CTRL, 32'hFFFE_FFFF);
        check("R10 irq after read", {31'b0, irq}, 32'd1);
        wr_irq("R5 stat hold", A_STAT, 32'hDFFE_FFFF, 1'b1);
        wr_irq("R5 stat bit16 lower", A_STAT, 32'h0001_0000, 1'b0);
        wr_irq("R3 raise again", A_OUTB, 32'h2000_0000, 1'b1);
        wr_irq("R5 stat bit29 lower", A_STAT, 32'h2000_0000, 1'b0);
        wr_irq("R4 ctrl hold low", A_CTRL, 32'h0, 1'b0);
        wr_irq("R3 raise third", A_OUTB, 32'h2000_0000, 1'b1);
        wr_irq("R4 ctrl bit16 lower", A_CTRL, 32'h0001_0000, 1'b0);
        rd_chk("R2 ctrl rb", A_CTRL, 32'h0003_0000);
        rd_chk("R5 stat stored", A_STAT, 32'h2000_0000);
    endtask

    task automatic t_soft;
        wr_irq("R6 set", A_SET, 32'h0000_000F, 1'b1);
        rd_chk("R8 via clr", A_CLR, 32'h0000_000F);
        wr_irq("R6 set or", A_SET, 32'h0000_00F0, 1'b1);
        rd_chk("R8 via set", A_SET, 32'h0000_00FF);
        wr_irq("R7 clr zero lowers", A_CLR, 32'h0, 1'b0);
        rd_chk("R7 clr zero keeps", A_SET, 32'h0000_00FF);
        wr_irq("R6 set zero raises", A_SET, 32'h0, 1'b1);
        wr_irq("R7 clr bits", A_CLR, 32'h0000_000F, 1'b0);
        rd_chk("R7 clr result", A_CLR, 32'h0000_00F0);
    endtask

    task automatic t_unmapped;
        logic [DW-1:0] r; logic e;
        wr_irq("R6 set before unmapped", A_SET, 32'h0, 1'b1);
        access(1'b1, 12'h030, 32'hFFFF_FFFF, r, e);
        check("R9 wr err", {31'b0, e}, 32'd1);
        check("R9 wr irq held", {31'b0, irq}, 32'd1);
        @(negedge clk);
        check("R9 err one cycle", {31'b0, rsp_err}, 32'd0);
        access(1'b1, 12'h02E, 32'hFFFF_FFFF, r, e);
        check("R9 misaligned err", {31'b0, e}, 32'd1);
        access(1'b0, 12'h1F8, '0, r, e);
        check("R9 rd data zero", r, 32'h0);
        check("R9 rd err", {31'b0, e}, 32'd1);
        rd_chk("R9 outb untouched", A_OUTB, 32'h2000_0000);
        rd_chk("R9 ctrl untouched", A_CTRL, 32'h0003_0000);
        rd_chk("R9 sw untouched", A_SET, 32'h0000_00F0);
        wr_irq("R7 clr lowers", A_CLR, 32'h0, 1'b0);
        access(1'b1, 12'h000, 32'h2001_0000, r, e);
        check("R9 irq held low", {31'b0, irq}, 32'd0);
        check("R9 err low addr", {31'b0, e}, 32'd1);
        repeat (3) @(negedge clk);
        check("R10 idle no rsp", {31'b0, rsp_valid}, 32'd0);
        check("R10 idle irq", {31'b0, irq}, 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_store();
        t_line_rules();
        t_soft();
        t_unmapped();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule